// File: doc/BRIEF.md
# Profiling record filter

This block sits between the unit that assembles a finished profiling sample and the unit that writes samples out to memory. Each incoming record carries an operation class, a vector of event flags and a latency count. Software configures three class enables, an event mask and a latency floor. The block decides for every record whether it is kept or dropped. A kept record is passed on unchanged. A dropped record goes no further, and the drop is added to a running tally.

Records enter through a valid/ready handshake and leave through another. One output register holds a kept record until the consumer takes it. A two-state controller manages that register. In state `ST_EMPTY` the register is free. The transition `EMPTY_TO_FULL` happens when a record is accepted and kept. In state `ST_FULL` a record waits on the output. The transition `FULL_TO_EMPTY` happens when the consumer takes the record and no new kept record arrives in the same cycle. The transition `FULL_REFILL` happens when the consumer takes the record and a new kept record is loaded in the same cycle. In every other case the controller stays in its present state.

Top module: `prof_rec_filter`

## Requirements
- R1: After reset, out_valid is 0, drop_count is 0 and in_ready is 1.
- R2: The operation class is coded on in_op as 0 = other, 1 = load, 2 = store, 3 = branch. When one or more of cfg_load_only, cfg_store_only and cfg_branch_only are set, a record passes the class check only if its class matches at least one of the enabled classes. When none of them is set, every class passes.
- R3: The event check passes only when every bit that is set in cfg_event_mask is also set in in_events. A mask of zero lets every record pass. The event bits are: bit 1 = retired, bit 3 = L1 data refill, bit 5 = TLB refill, bit 7 = mispredict, bit 11 = misaligned. For example, a mask of 0x002 keeps only retired operations, and a mask of 0x080 keeps only mispredicted operations.
- R4: The latency check passes when in_lat >= cfg_min_lat. A threshold of 0 lets every record pass.
- R5: A kept record appears on out_op, out_events and out_lat with its values unchanged, in the cycle after it is accepted. While out_valid=1 and out_ready=0, the output holds and stays stable.
- R6: A dropped record never appears on the output. Each drop raises drop_count by one.
- R7: in_ready is 1 when the output register is empty or when out_ready=1. Records can therefore be accepted one per clock cycle while the consumer is ready.
- R8: drop_clear=1 sets drop_count to 0 at the next edge. If a drop happens in the same cycle, the counter becomes 1 instead.
- R9: drop_count saturates at its all-ones value.
- R10: A record is kept only when the class, event and latency checks all pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_only | input | 1 | Enable: keep load records |
| cfg_store_only | input | 1 | Enable: keep store records |
| cfg_branch_only | input | 1 | Enable: keep branch records |
| cfg_event_mask | input | EV_W | Event flags that a record must all carry |
| cfg_min_lat | input | LAT_W | Minimum latency that is kept |
| in_valid | input | 1 | Incoming record valid |
| in_ready | output | 1 | Block can take a record |
| in_op | input | 2 | Operation class of the incoming record |
| in_events | input | EV_W | Event flags of the incoming record |
| in_lat | input | LAT_W | Latency of the incoming record |
| out_valid | output | 1 | Kept record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 2 | Operation class of the kept record |
| out_events | output | EV_W | Event flags of the kept record |
| out_lat | output | LAT_W | Latency of the kept record |
| drop_clear | input | 1 | Clear the drop tally |
| drop_count | output | CNT_W | Number of dropped records |

## Verification
The decision logic is tested one filter at a time, then in combination:
- **Class filter:** a mixed stream of all four classes runs under a single enable and then under two enables. This separates OR-ing of the enables from AND-ing them.
- **Event filter:** the masks 0x002, 0x080 and 0x028 are each tried against records that carry the required flags, some of them, or none of them. The two-bit mask shows that every required flag must be present, not just any one.
- **Latency filter:** latencies one below, equal to and one above the threshold mark the boundary of the comparison.
- **Combined filters:** records that fail exactly one of the three checks show that all checks must agree.
- **Output handshake:** a toggling consumer-ready pattern and a fully stalled consumer exercise output hold, refill in the same cycle as a take, and input back-pressure.
- **Drop tally:** long drop runs and clear pulses, one of them in the same cycle as a drop, test the clear priority and saturation.

// File: rtl/prof_filt_pkg.sv
package prof_filt_pkg;

    typedef enum logic [1:0] {
        OPC_OTHER  = 2'd0,
        OPC_LOAD   = 2'd1,
        OPC_STORE  = 2'd2,
        OPC_BRANCH = 2'd3
    } opc_e;

    localparam int NUM_CLASSES = 3;

    localparam int EVB_RETIRED    = 1;
    localparam int EVB_L1D_REFILL = 3;
    localparam int EVB_TLB_REFILL = 5;
    localparam int EVB_MISPREDICT = 7;
    localparam int EVB_MISALIGNED = 11;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/prof_type_chk.sv
module prof_type_chk
    import prof_filt_pkg::*;
(
    input  logic [1:0]             op,
    input  logic [NUM_CLASSES-1:0] class_en,
    output logic                   pass
);

    logic [NUM_CLASSES-1:0] hit;

    // Enable i selects the class whose code is i+1 (load, store, branch).
    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_class
        assign hit[i] = class_en[i] && (op == 2'(i + 1));
    end

    assign pass = ~(|class_en) | (|hit);

endmodule

// File: rtl/prof_event_chk.sv
module prof_event_chk #(
    parameter int EV_W = 12
) (
    input  logic [EV_W-1:0] events,
    input  logic [EV_W-1:0] mask,
    output logic            pass
);

    logic [EV_W-1:0] bit_ok;

    for (genvar i = 0; i < EV_W; i++) begin : g_bit
        assign bit_ok[i] = ~mask[i] | events[i];
    end

    assign pass = &bit_ok;

endmodule

// File: rtl/prof_lat_chk.sv
module prof_lat_chk #(
    parameter int LAT_W = 12
) (
    input  logic [LAT_W-1:0] lat,
    input  logic [LAT_W-1:0] min_lat,
    output logic             pass
);

    assign pass = (lat >= min_lat);

endmodule

// File: rtl/prof_drop_ctr.sv
module prof_drop_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? CNT_W'(1) : '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/prof_rec_filter.sv
module prof_rec_filter
    import prof_filt_pkg::*;
#(
    parameter int EV_W  = 12,
    parameter int LAT_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_only,
    input  logic             cfg_store_only,
    input  logic             cfg_branch_only,
    input  logic [EV_W-1:0]  cfg_event_mask,
    input  logic [LAT_W-1:0] cfg_min_lat,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic [EV_W-1:0]  in_events,
    input  logic [LAT_W-1:0] in_lat,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_op,
    output logic [EV_W-1:0]  out_events,
    output logic [LAT_W-1:0] out_lat,
    input  logic             drop_clear,
    output logic [CNT_W-1:0] drop_count
);

    slot_state_e state_q, state_d;

    logic type_ok, event_ok, lat_ok;
    logic keep, accept, load_slot, drop_inc;

    prof_type_chk u_type (
        .op       (in_op),
        .class_en ({cfg_branch_only, cfg_store_only, cfg_load_only}),
        .pass     (type_ok)
    );

    prof_event_chk #(.EV_W(EV_W)) u_event (
        .events (in_events),
        .mask   (cfg_event_mask),
        .pass   (event_ok)
    );

    prof_lat_chk #(.LAT_W(LAT_W)) u_lat (
        .lat     (in_lat),
        .min_lat (cfg_min_lat),
        .pass    (lat_ok)
    );

    prof_drop_ctr #(.CNT_W(CNT_W)) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_inc),
        .clr   (drop_clear),
        .count (drop_count)
    );

    assign keep      = type_ok & event_ok & lat_ok;
    assign accept    = in_valid & in_ready;
    assign load_slot = accept & keep;
    assign drop_inc  = accept & ~keep;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (load_slot) state_d = ST_FULL;        // EMPTY_TO_FULL
            end
            ST_FULL: begin
                if (out_ready && !load_slot) state_d = ST_EMPTY; // FULL_TO_EMPTY
                // FULL_REFILL keeps ST_FULL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: begin
                out_valid = 1'b0;
                in_ready  = 1'b0;
            end
        endcase
    end

    // Output data register, loaded only with kept records
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_op     <= '0;
            out_events <= '0;
            out_lat    <= '0;
        end else if (load_slot) begin
            out_op     <= in_op;
            out_events <= in_events;
            out_lat    <= in_lat;
        end
    end

endmodule

// File: rtl/prof_rec_filter_chk.sv
module prof_rec_filter_chk #(
    parameter int EV_W  = 12,
    parameter int LAT_W = 12,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load_only,
    input logic             cfg_store_only,
    input logic             cfg_branch_only,
    input logic [EV_W-1:0]  cfg_event_mask,
    input logic [LAT_W-1:0] cfg_min_lat,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic [EV_W-1:0]  in_events,
    input logic [LAT_W-1:0] in_lat,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_op,
    input logic [EV_W-1:0]  out_events,
    input logic [LAT_W-1:0] out_lat,
    input logic             drop_clear,
    input logic [CNT_W-1:0] drop_count
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op)
                                       && $stable(out_events) && $stable(out_lat)));

    a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r7_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    a_r2_class_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (cfg_load_only || cfg_store_only || cfg_branch_only)
         && !(cfg_load_only && in_op == 2'd1)
         && !(cfg_store_only && in_op == 2'd2)
         && !(cfg_branch_only && in_op == 2'd3)) |=> !out_valid);

    a_r3_event_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ((in_events & cfg_event_mask) != cfg_event_mask))
        |=> !out_valid);

    a_r4_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_lat < cfg_min_lat)) |=> !out_valid);

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop_clear && drop_count != CMAX) |=>
        (drop_count == $past(drop_count) || drop_count == $past(drop_count) + CNT_W'(1)));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        drop_clear |=> (drop_count <= CNT_W'(1)));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == CMAX && !drop_clear) |=> (drop_count == CMAX));

endmodule

bind prof_rec_filter prof_rec_filter_chk #(
    .EV_W  (EV_W),
    .LAT_W (LAT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_load_only   (cfg_load_only),
    .cfg_store_only  (cfg_store_only),
    .cfg_branch_only (cfg_branch_only),
    .cfg_event_mask  (cfg_event_mask),
    .cfg_min_lat     (cfg_min_lat),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_op           (in_op),
    .in_events       (in_events),
    .in_lat          (in_lat),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_op          (out_op),
    .out_events      (out_events),
    .out_lat         (out_lat),
    .drop_clear      (drop_clear),
    .drop_count      (drop_count)
);

// File: tb/prof_rec_filter_bench.sv
module prof_rec_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EVW = 12;
    localparam int LW  = 12;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ld = 0, cfg_st = 0, cfg_br = 0;
    logic [EVW-1:0] cfg_mask = '0;
    logic [LW-1:0]  cfg_min = '0;
    logic in_valid = 0;
    logic in_ready;
    logic [1:0] in_op = '0;
    logic [EVW-1:0] in_events = '0;
    logic [LW-1:0] in_lat = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [1:0] out_op;
    logic [EVW-1:0] out_events;
    logic [LW-1:0] out_lat;
    logic drop_clear = 1'b0;
    logic [CW-1:0] drop_count;

    int checks = 0;
    int failures = 0;
    int rdy_mode = 0;   // 0 always ready, 1 never ready, 2 toggling pattern
    int cyc = 0;
    int exp_drop = 0;
    logic [2+EVW+LW-1:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prof_rec_filter #(.EV_W(EVW), .LAT_W(LW), .CNT_W(CW)) u_prof_rec_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_load_only(cfg_ld), .cfg_store_only(cfg_st), .cfg_branch_only(cfg_br),
        .cfg_event_mask(cfg_mask), .cfg_min_lat(cfg_min),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_events(in_events), .in_lat(in_lat),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_op(out_op), .out_events(out_events), .out_lat(out_lat),
        .drop_clear(drop_clear), .drop_count(drop_count)
    );

    task automatic check(input string req, input logic ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Consumer ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: out_ready = ((cyc % 3) != 0);
        endcase
    end

    // Reference decision from the requirements
    function automatic logic ref_keep(input logic [1:0] op, input logic [EVW-1:0] ev,
                                      input logic [LW-1:0] lat);
        logic cls_ok, ev_ok, lat_ok;
        cls_ok = !(cfg_ld || cfg_st || cfg_br)
                 || (cfg_ld && op == 2'd1) || (cfg_st && op == 2'd2) || (cfg_br && op == 2'd3);
        ev_ok  = ((ev & cfg_mask) == cfg_mask);
        lat_ok = (lat >= cfg_min);
        return cls_ok && ev_ok && lat_ok;
    endfunction

    task automatic send(input logic [1:0] op, input logic [EVW-1:0] ev,
                        input logic [LW-1:0] lat, input logic clr);
        logic k;
        @(negedge clk); #1;
        in_valid = 1'b1; in_op = op; in_events = ev; in_lat = lat; drop_clear = clr;
        k = ref_keep(op, ev, lat);
        if (k) sb_q.push_back({op, ev, lat});
        if (clr) exp_drop = k ? 0 : 1;
        else if (!k && exp_drop < 255) exp_drop++;
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; drop_clear = 1'b0;
    endtask

    task automatic set_cfg(input logic l, input logic s, input logic b,
                           input logic [EVW-1:0] m, input logic [LW-1:0] mn);
        @(negedge clk);
        cfg_ld = l; cfg_st = s; cfg_br = b; cfg_mask = m; cfg_min = mn;
    endtask

    task automatic drain();
        int n = 0;
        while (sb_q.size() != 0 && n < 200) begin
            @(negedge clk); n++;
        end
        check("R6 queue drained", sb_q.size() == 0, sb_q.size(), 0);
        @(negedge clk);
    endtask

    task automatic check_drops(input string req);
        @(negedge clk);
        check(req, drop_count == CW'(exp_drop), drop_count, exp_drop);
    endtask

    // Monitor: compare every transfer against the scoreboard, and the hold rule
    logic held = 1'b0;
    logic [2+EVW+LW-1:0] held_rec;
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check("R5 hold while stalled",
                      out_valid && ({out_op, out_events, out_lat} == held_rec),
                      {out_op, out_events, out_lat}, held_rec);
            end
            held = 1'b0;
            if (out_valid && out_ready) begin
                if (sb_q.size() == 0) begin
                    check("R6 unexpected output", 1'b0, {out_op, out_events, out_lat}, 0);
                end else begin
                    logic [2+EVW+LW-1:0] e;
                    e = sb_q.pop_front();
                    check("R5 R10 forwarded record", {out_op, out_events, out_lat} == e,
                          {out_op, out_events, out_lat}, e);
                end
            end else if (out_valid) begin
                held = 1'b1;
                held_rec = {out_op, out_events, out_lat};
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid reset", out_valid == 1'b0, out_valid, 0);
        check("R1 drop_count reset", drop_count == '0, drop_count, 0);
        check("R1 in_ready reset", in_ready == 1'b1, in_ready, 1);
        rst_n = 1'b1;

        // Pass-all configuration
        set_cfg(0, 0, 0, '0, '0);
        send(2'd0, 12'h000, 12'd0, 0);
        send(2'd1, 12'hABC, 12'd77, 0);
        send(2'd2, 12'hFFF, 12'hFFF, 0);
        send(2'd3, 12'h080, 12'd5, 0);
        drain();
        check_drops("R2 R3 R4 nothing dropped with filters off");

        // R2: load only
        set_cfg(1, 0, 0, '0, '0);
        for (int i = 0; i < 4; i++) send(2'(i), 12'h002, 12'd3, 0);
        drain();
        check_drops("R2 load only drops three");
        // R2: load or branch
        set_cfg(1, 0, 1, '0, '0);
        for (int i = 0; i < 4; i++) send(2'(i), 12'h002, 12'd3, 0);
        drain();
        check_drops("R2 load or branch drops two");
        // R2: store only
        set_cfg(0, 1, 0, '0, '0);
        for (int i = 0; i < 4; i++) send(2'(i), 12'h000, 12'd9, 0);
        drain();
        check_drops("R2 store only");

        // R3: retired only (bit 1)
        set_cfg(0, 0, 0, 12'h002, '0);
        send(2'd1, 12'h002, 12'd1, 0);
        send(2'd1, 12'h000, 12'd1, 0);
        send(2'd2, 12'h8AA, 12'd1, 0);
        drain();
        check_drops("R3 retired mask");
        // R3: mispredict only (bit 7)
        set_cfg(0, 0, 0, 12'h080, '0);
        send(2'd3, 12'h082, 12'd1, 0);
        send(2'd3, 12'h002, 12'd1, 0);
        drain();
        check_drops("R3 mispredict mask");
        // R3: L1D refill and TLB refill both required (bits 3 and 5)
        set_cfg(0, 0, 0, 12'h028, '0);
        send(2'd1, 12'h008, 12'd1, 0);
        send(2'd1, 12'h020, 12'd1, 0);
        send(2'd1, 12'h028, 12'd1, 0);
        send(2'd1, 12'h800, 12'd1, 0);
        drain();
        check_drops("R3 all mask bits required");

        // R4: latency boundary
        set_cfg(0, 0, 0, '0, 12'd10);
        send(2'd1, 12'h0, 12'd9, 0);
        send(2'd1, 12'h0, 12'd10, 0);
        send(2'd1, 12'h0, 12'd11, 0);
        send(2'd1, 12'h0, 12'd0, 0);
        drain();
        check_drops("R4 latency threshold");

        // R10: each record fails exactly one check, last one passes all
        set_cfg(1, 0, 0, 12'h800, 12'd20);
        send(2'd2, 12'h800, 12'd30, 0);
        send(2'd1, 12'h000, 12'd30, 0);
        send(2'd1, 12'h800, 12'd19, 0);
        send(2'd1, 12'hC00, 12'd20, 0);
        drain();
        check_drops("R10 combined checks");

        // R7: stalled consumer blocks input
        set_cfg(0, 0, 0, '0, '0);
        rdy_mode = 1;
        @(negedge clk);
        send(2'd2, 12'h123, 12'd44, 0);
        @(negedge clk); #1;
        check("R7 in_ready low while stalled", in_ready == 1'b0, in_ready, 0);
        check("R5 record held", out_valid == 1'b1 && out_lat == 12'd44, out_lat, 44);
        rdy_mode = 0;
        drain();

        // R5 R7: toggling ready with a mixed stream
        rdy_mode = 2;
        set_cfg(0, 0, 0, '0, 12'd4);
        for (int i = 0; i < 16; i++) send(2'(i % 4), 12'(i * 37), 12'(i), 0);
        rdy_mode = 0;
        drain();
        check_drops("R6 toggling ready drops");

        // R8: clear, then clear coinciding with a drop
        @(negedge clk); drop_clear = 1'b1;
        @(negedge clk); drop_clear = 1'b0;
        exp_drop = 0;
        check_drops("R8 clear to zero");
        send(2'd0, 12'h0, 12'd1, 0);
        send(2'd0, 12'h0, 12'd1, 1);
        check_drops("R8 clear with simultaneous drop");

        // R9: saturation
        for (int i = 0; i < 300; i++) send(2'd0, 12'h0, 12'd0, 0);
        check_drops("R9 saturation");
        send(2'd0, 12'h0, 12'd0, 0);
        check_drops("R9 stays saturated");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule